// File: doc/BRIEF.md
# In-order issue hazard interlock

This block holds back a single-issue, in-order pipeline until the operands of the instruction waiting at decode are ready. Each cycle decode shows it one instruction: an operation class, up to two source register references and an optional destination reference. A reference names a register in either the integer file or the FP file, each of 32 entries. When the instruction issues and writes a register, the block records the producing class and a count of cycles still outstanding for that register. A later instruction that reads the register is stalled for the number of bubbles that the producer/consumer pairing calls for.

The required bubbles come from a fixed table indexed by producer class and by the way the consumer uses the operand. An operand is used in one of three ways: general use, store data, or branch compare. Store data needs fewer bubbles after FP results than other uses do. Upstream keeps the instruction steady while `stall` is high, and the instruction issues in the cycle in which `issue_ok` is high. A free-running counter totals stall cycles so that schedules can be measured. Forwarding paths, functional units and branch prediction are not part of this block.

Top module: `hazard_interlock`

Class codes on `in_cls`: 0 load, 1 store, 2 FP add, 3 FP multiply, 4 integer ALU, 5 branch. The operand on source A is the general operand, which for a store is the address. The operand on source B is the store data for a store and a compare operand for a branch. Bubble counts are measured from the cycle in which the producer issues. A consumer that arrives in the next cycle sees the full count, and every cycle that passes in between, idle or stalled, removes one bubble.

## Requirements
- R1: A load result makes any dependent instruction wait 1 stall cycle, whatever the operand use.
- R2: An FP add result costs 3 stall cycles for general and branch use, and 2 when it feeds the store data operand (source B of class 1).
- R3: An FP multiply result costs 5 stall cycles for general and branch use, and 4 when it feeds store data. Cycles that elapse after the producer issues reduce the wait one for one.
- R4: An integer ALU result costs 1 stall cycle when read by a branch (class 5) and none for any other consumer.
- R5: A store's address operand (source A) pays the general latency, not the store-data latency.
- R6: The stall length is the largest remaining wait over the valid sources. A source whose valid bit is low has no effect, and an instruction with no valid source issues at once.
- R7: Store and branch instructions never create a pending entry, even when their destination valid bit is set.
- R8: A later producer to the same register replaces the earlier pending entry. The integer and FP files are tracked apart, so the same index in the other file is no hazard.
- R9: With `in_valid` high, exactly one of `stall` and `issue_ok` is high. With it low, both are low. `stall_cycles` increments by one in each cycle in which `stall` is high and otherwise holds its value.
- R10: A synchronous active-high reset clears all pending entries and `stall_cycles`.
- R11: An instruction that is held unchanged is never stalled for more than 5 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_cls | input | 3 | Operation class code |
| src_a_vld | input | 1 | Source A is read |
| src_a_fp | input | 1 | Source A is in the FP file (0 = integer file) |
| src_a_idx | input | 5 | Source A register index |
| src_b_vld | input | 1 | Source B is read |
| src_b_fp | input | 1 | Source B is in the FP file |
| src_b_idx | input | 5 | Source B register index |
| dst_vld | input | 1 | Instruction names a destination |
| dst_fp | input | 1 | Destination is in the FP file |
| dst_idx | input | 5 | Destination register index |
| issue_ok | output | 1 | The presented instruction issues this cycle |
| stall | output | 1 | The presented instruction must be held |
| stall_cycles | output | 16 | Running total of stall cycles |

## Verification
The hardest case to reach is two pending producers with different latencies, each partly drained, both read by one instruction. In that case the longer remaining wait must win. The case also covers a register that was rewritten by a shorter-latency producer before it was read, where only the newer entry may count. Directed sequences set these up by issuing an FP multiply and then a load or FP add in consecutive cycles, then presenting the consumer at a chosen distance. A long random stream on a four-register working set in both files keeps the entries colliding, and a behavioural timestamp model checks every cycle of it.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int BUBW = 3;
    localparam int MAX_BUBBLES = 5;

    typedef enum logic [2:0] {
        CLS_LOAD   = 3'd0,
        CLS_STORE  = 3'd1,
        CLS_FADD   = 3'd2,
        CLS_FMUL   = 3'd3,
        CLS_IALU   = 3'd4,
        CLS_BRANCH = 3'd5
    } op_cls_e;

    typedef enum logic [1:0] {
        ROLE_GEN    = 2'd0,
        ROLE_STDATA = 2'd1,
        ROLE_BRANCH = 2'd2
    } opnd_role_e;

    typedef struct packed {
        logic [BUBW-1:0] cnt;
        op_cls_e         cls;
    } sb_entry_t;

    // bubbles owed by a producer class to a consumer operand role
    function automatic logic [BUBW-1:0] bubbles(op_cls_e p, opnd_role_e r);
        case (p)
            CLS_LOAD: return BUBW'(1);
            CLS_FADD: return (r == ROLE_STDATA) ? BUBW'(2) : BUBW'(3);
            CLS_FMUL: return (r == ROLE_STDATA) ? BUBW'(4) : BUBW'(5);
            CLS_IALU: return (r == ROLE_BRANCH) ? BUBW'(1) : BUBW'(0);
            default:  return BUBW'(0);
        endcase
    endfunction

    // longest wait a producer can impose, used as the entry load value
    function automatic logic [BUBW-1:0] hold_bubbles(op_cls_e p);
        logic [BUBW-1:0] m;
        m = bubbles(p, ROLE_GEN);
        if (bubbles(p, ROLE_STDATA) > m) m = bubbles(p, ROLE_STDATA);
        if (bubbles(p, ROLE_BRANCH) > m) m = bubbles(p, ROLE_BRANCH);
        return m;
    endfunction

    function automatic logic writes_reg(op_cls_e c);
        return !(c == CLS_STORE || c == CLS_BRANCH);
    endfunction

endpackage

// File: rtl/hz_scoreboard.sv
module hz_scoreboard
    import hz_pkg::*;
#(
    parameter int NENT = 64,
    localparam int IW = $clog2(NENT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_a_ix,
    input  logic [IW-1:0] rd_b_ix,
    output sb_entry_t     ent_a,
    output sb_entry_t     ent_b,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_ix,
    input  op_cls_e       wr_cls
);

    sb_entry_t tbl [NENT];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NENT; i++) begin
            if (rst) begin
                tbl[i].cnt <= '0;
                tbl[i].cls <= CLS_IALU;
            end else if (wr_en && wr_ix == IW'(i)) begin
                tbl[i].cnt <= hold_bubbles(wr_cls);
                tbl[i].cls <= wr_cls;
            end else if (tbl[i].cnt != '0) begin
                tbl[i].cnt <= tbl[i].cnt - 1'b1;
            end
        end
    end

    assign ent_a = tbl[rd_a_ix];
    assign ent_b = tbl[rd_b_ix];

endmodule

// File: rtl/hz_source_wait.sv
module hz_source_wait
    import hz_pkg::*;
(
    input  logic            src_vld,
    input  sb_entry_t       ent,
    input  opnd_role_e      role,
    output logic [BUBW-1:0] wcyc
);

    logic [BUBW-1:0] need;
    logic [BUBW-1:0] slack;

    always_comb begin
        need  = bubbles(ent.cls, role);
        slack = hold_bubbles(ent.cls) - need;
        if (src_vld && ent.cnt > slack) wcyc = ent.cnt - slack;
        else                            wcyc = '0;
    end

endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
    import hz_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int CNT_W = 16,
    localparam int RW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_cls,
    input  logic             src_a_vld,
    input  logic             src_a_fp,
    input  logic [RW-1:0]    src_a_idx,
    input  logic             src_b_vld,
    input  logic             src_b_fp,
    input  logic [RW-1:0]    src_b_idx,
    input  logic             dst_vld,
    input  logic             dst_fp,
    input  logic [RW-1:0]    dst_idx,
    output logic             issue_ok,
    output logic             stall,
    output logic [CNT_W-1:0] stall_cycles
);

    localparam int NENT = 2 * NREG;
    localparam int NSRC = 2;

    op_cls_e         cls;
    logic [RW:0]     s_ix  [NSRC];
    logic            s_vld [NSRC];
    sb_entry_t       s_ent [NSRC];
    opnd_role_e      s_role[NSRC];
    logic [BUBW-1:0] s_wait[NSRC];
    logic [BUBW-1:0] need;
    logic            wr_en;

    assign cls      = op_cls_e'(in_cls);
    assign s_ix[0]  = {src_a_fp, src_a_idx};
    assign s_ix[1]  = {src_b_fp, src_b_idx};
    assign s_vld[0] = src_a_vld;
    assign s_vld[1] = src_b_vld;

    hz_scoreboard #(.NENT(NENT)) u_sb (
        .clk     (clk),
        .rst     (rst),
        .rd_a_ix (s_ix[0]),
        .rd_b_ix (s_ix[1]),
        .ent_a   (s_ent[0]),
        .ent_b   (s_ent[1]),
        .wr_en   (wr_en),
        .wr_ix   ({dst_fp, dst_idx}),
        .wr_cls  (cls)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (g == 0) begin : g_gen
            // source A: general operand (store address)
            assign s_role[g] = (cls == CLS_BRANCH) ? ROLE_BRANCH : ROLE_GEN;
        end else begin : g_dat
            // source B: store data or branch compare
            assign s_role[g] = (cls == CLS_STORE)  ? ROLE_STDATA :
                               (cls == CLS_BRANCH) ? ROLE_BRANCH : ROLE_GEN;
        end
        hz_source_wait u_wait (
            .src_vld (s_vld[g]),
            .ent     (s_ent[g]),
            .role    (s_role[g]),
            .wcyc    (s_wait[g])
        );
    end

    assign need     = (s_wait[0] > s_wait[1]) ? s_wait[0] : s_wait[1];
    assign stall    = in_valid && (need != '0);
    assign issue_ok = in_valid && (need == '0);
    assign wr_en    = issue_ok && dst_vld && writes_reg(cls);

    always_ff @(posedge clk) begin
        if (rst)        stall_cycles <= '0;
        else if (stall) stall_cycles <= stall_cycles + 1'b1;
    end

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk
    import hz_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int CNT_W = 16,
    localparam int RW   = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       in_cls,
    input logic             src_a_vld,
    input logic             src_a_fp,
    input logic [RW-1:0]    src_a_idx,
    input logic             src_b_vld,
    input logic             src_b_fp,
    input logic [RW-1:0]    src_b_idx,
    input logic             dst_vld,
    input logic             dst_fp,
    input logic [RW-1:0]    dst_idx,
    input logic             issue_ok,
    input logic             stall,
    input logic [CNT_W-1:0] stall_cycles
);

    localparam int IN_W = 3 + 2 * (2 + RW) + (2 + RW);

    logic [IN_W-1:0] cur_in, prev_in;
    logic            prev_stall;
    logic [3:0]      run_q;

    assign cur_in = {in_cls, src_a_vld, src_a_fp, src_a_idx,
                     src_b_vld, src_b_fp, src_b_idx, dst_vld, dst_fp, dst_idx};

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_in    <= '0;
            prev_stall <= 1'b0;
            run_q      <= '0;
        end else begin
            prev_in    <= cur_in;
            prev_stall <= stall;
            if (!stall)                             run_q <= '0;
            else if (prev_stall && prev_in == cur_in) run_q <= run_q + 1'b1;
            else                                    run_q <= 4'd1;
        end
    end

    p_one_of_two_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (stall != issue_ok));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> (!stall && !issue_ok));

    p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
        stall |=> stall_cycles == CNT_W'($past(stall_cycles) + 1'b1));

    p_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !stall |=> $stable(stall_cycles));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (stall_cycles == '0));

    p_no_source_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !src_a_vld && !src_b_vld) |-> issue_ok);

    p_run_bound_r11: assert property (@(posedge clk) disable iff (rst)
        run_q <= 4'(MAX_BUBBLES));

endmodule

bind hazard_interlock hz_interlock_chk #(.NREG(NREG), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/hazard_interlock_bench.sv
`timescale 1ns/1ps
module hazard_interlock_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_cls = 3'd4;
    logic        src_a_vld = 1'b0, src_a_fp = 1'b0, src_b_vld = 1'b0, src_b_fp = 1'b0;
    logic        dst_vld = 1'b0, dst_fp = 1'b0;
    logic [4:0]  src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
    logic        issue_ok, stall;
    logic [15:0] stall_cycles;

    always #2.5 clk = ~clk;

    hazard_interlock u_hazard_interlock (.*);

    // codes
    localparam int LD = 0, ST = 1, FA = 2, FM = 3, IA = 4, BR = 5;
    localparam int RG = 0, RS = 1, RB = 2;

    int tests = 0, fails = 0;
    int cyc = 0;
    int exp_cnt = 0;
    bit live [64];
    int t_iss [64];
    int p_cls [64];
    bit seen_issue, seen_stall;

    function automatic int lat(int p, int role);
        case (p)
            LD: return 1;
            FA: return (role == RS) ? 2 : 3;
            FM: return (role == RS) ? 4 : 5;
            IA: return (role == RB) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int src_need(bit v, bit fp, int idx, int role);
        int k, n;
        if (!v) return 0;
        k = fp * 32 + idx;
        if (!live[k]) return 0;
        n = lat(p_cls[k], role) + 1 - (cyc - t_iss[k]);
        return (n < 0) ? 0 : n;
    endfunction

    task automatic clear_model();
        for (int i = 0; i < 64; i++) live[i] = 1'b0;
        exp_cnt = 0;
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // one clock: compare against model, then advance model over the edge
    task automatic step();
        int na, nb, need, c;
        bit e_stall, e_issue;
        #1;
        c    = int'(in_cls);
        na   = src_need(src_a_vld, src_a_fp, int'(src_a_idx), (c == BR) ? RB : RG);
        nb   = src_need(src_b_vld, src_b_fp, int'(src_b_idx),
                        (c == ST) ? RS : (c == BR) ? RB : RG);
        need = (na > nb) ? na : nb;
        e_stall = in_valid && need > 0;
        e_issue = in_valid && need == 0;
        seen_issue = issue_ok;
        seen_stall = stall;
        check(stall == e_stall, "R9", "stall vs model", int'(stall), int'(e_stall));
        check(issue_ok == e_issue, "R9", "issue_ok vs model", int'(issue_ok), int'(e_issue));
        check(stall_cycles == 16'(exp_cnt), "R9", "stall_cycles", int'(stall_cycles), exp_cnt);
        @(posedge clk);
        if (e_issue && dst_vld && c != ST && c != BR) begin
            live[dst_fp * 32 + int'(dst_idx)] = 1'b1;
            t_iss[dst_fp * 32 + int'(dst_idx)] = cyc;
            p_cls[dst_fp * 32 + int'(dst_idx)] = c;
        end
        if (e_stall) exp_cnt++;
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    // present one instruction until it issues; exp < 0 skips the length check
    task automatic issue(int c, bit av, bit af, int ai, bit bv, bit bf, int bi,
                         bit dv, bit df, int di, int exp, string req);
        int n;
        in_valid = 1'b1; in_cls = 3'(c);
        src_a_vld = av; src_a_fp = af; src_a_idx = 5'(ai);
        src_b_vld = bv; src_b_fp = bf; src_b_idx = 5'(bi);
        dst_vld = dv; dst_fp = df; dst_idx = 5'(di);
        n = 0;
        for (int g = 0; g < 20; g++) begin
            step();
            if (seen_issue) break;
            if (seen_stall) n++;
        end
        if (exp >= 0) check(n == exp, req, "stall cycles before issue", n, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired: actual 1 expected 0");
        finish_run();
    end

    initial begin
        clear_model();
        do_reset();
        #1;
        check(!stall && !issue_ok, "R10", "outputs after reset", int'({stall, issue_ok}), 0);
        check(stall_cycles == 0, "R10", "counter after reset", int'(stall_cycles), 0);
        @(negedge clk);

        // R1: load -> integer use, and load -> store data
        issue(LD, 1,0,1, 0,0,0, 1,0,3, 0, "R1");
        issue(IA, 1,0,3, 0,0,0, 1,0,4, 1, "R1");
        issue(LD, 1,0,1, 0,0,0, 1,1,6, 0, "R1");
        issue(ST, 1,0,1, 1,1,6, 0,0,0, 1, "R1");
        idle(6);
        // R2: FP add general 3, store data 2
        issue(FA, 1,1,1, 1,1,2, 1,1,4, 0, "R2");
        issue(FA, 1,1,4, 0,0,0, 1,1,5, 3, "R2");
        idle(6);
        issue(FA, 1,1,1, 1,1,2, 1,1,4, 0, "R2");
        issue(ST, 1,0,1, 1,1,4, 0,0,0, 2, "R2");
        idle(6);
        // R5: FP add result on the store address operand pays general latency
        issue(FA, 1,1,1, 1,1,2, 1,1,8, 0, "R5");
        issue(ST, 1,1,8, 0,0,0, 0,0,0, 3, "R5");
        idle(6);
        // R3: FP multiply general 5, store data 4, shortened by elapsed cycles
        issue(FM, 1,1,1, 1,1,2, 1,1,12, 0, "R3");
        issue(FA, 1,1,12, 0,0,0, 1,1,13, 5, "R3");
        idle(6);
        issue(FM, 1,1,1, 1,1,2, 1,1,12, 0, "R3");
        issue(ST, 1,0,1, 1,1,12, 0,0,0, 4, "R3");
        idle(6);
        issue(FM, 1,1,1, 1,1,2, 1,1,11, 0, "R3");
        idle(3);
        issue(FA, 1,1,11, 0,0,0, 1,1,14, 2, "R3");
        idle(6);
        // R4: integer ALU -> branch 1, -> integer ALU 0
        issue(IA, 1,0,1, 0,0,0, 1,0,5, 0, "R4");
        issue(BR, 1,0,5, 1,0,1, 0,0,0, 1, "R4");
        issue(IA, 1,0,1, 0,0,0, 1,0,6, 0, "R4");
        issue(IA, 1,0,6, 1,0,6, 1,0,7, 0, "R4");
        idle(6);
        // R6: maximum over two partly drained producers
        issue(FM, 1,1,0, 0,0,0, 1,1,1, 0, "R6");
        issue(FA, 1,1,0, 0,0,0, 1,1,2, 0, "R6");
        issue(FA, 1,1,1, 1,1,2, 1,1,3, 4, "R6");
        idle(6);
        // R6: invalid source pointing at a pending register is ignored
        issue(FM, 1,1,0, 0,0,0, 1,1,9, 0, "R6");
        issue(FA, 1,1,0, 0,1,9, 1,1,10, 0, "R6");
        idle(6);
        // R7: store and branch with destination valid create no entry
        issue(ST, 1,0,1, 1,1,0, 1,1,7, 0, "R7");
        issue(FA, 1,1,7, 0,0,0, 1,1,15, 0, "R7");
        issue(BR, 1,0,1, 1,0,2, 1,0,9, 0, "R7");
        issue(BR, 1,0,9, 0,0,0, 0,0,0, 0, "R7");
        idle(6);
        // R8: overwrite by a shorter producer, and file separation
        issue(FM, 1,1,0, 0,0,0, 1,1,20, 0, "R8");
        issue(LD, 1,0,1, 0,0,0, 1,1,20, 0, "R8");
        issue(FA, 1,1,20, 0,0,0, 1,1,21, 1, "R8");
        idle(6);
        issue(FM, 1,1,0, 0,0,0, 1,1,10, 0, "R8");
        issue(IA, 1,0,10, 0,0,0, 1,0,11, 0, "R8");
        idle(6);
        // R10: reset mid-flight drops a pending multiply
        issue(FM, 1,1,0, 0,0,0, 1,1,16, 0, "R10");
        in_valid = 1'b0;
        do_reset();
        issue(FA, 1,1,16, 0,0,0, 1,1,17, 0, "R10");
        idle(2);

        // random stream on a small working set, model checked every cycle
        for (int k = 0; k < 1500; k++) begin
            int c;
            c = $urandom_range(0, 5);
            if ($urandom_range(0, 5) == 0) idle(1);
            issue(c, 1'($urandom_range(0,1)), 1'($urandom_range(0,1)), $urandom_range(0,3),
                  1'($urandom_range(0,1)), 1'($urandom_range(0,1)), $urandom_range(0,3),
                  1'($urandom_range(0,1)), 1'($urandom_range(0,1)), $urandom_range(0,3),
                  -1, "R6");
        end
        idle(4);
        finish_run();
    end

endmodule